// File: doc/BRIEF.md
# RV32I Next-PC Branch Unit

This unit holds the program counter of a simple RV32I core and works out the next one. It covers every control-transfer instruction the base set defines: the six conditional branches, the direct jump with link, and the register-indirect jump with link. It takes the instruction word and the two source operand values, and combinationally presents the next PC. It also presents a link-register write (enable, destination index and data) and a misaligned-target exception flag. On each clock edge with a qualified instruction, the PC register loads the next PC, unless the exception flag is raised.

Branch and jump offsets arrive scattered across the instruction word. The unit gathers and sign-extends them itself. Any instruction that is not a control transfer advances the PC by four. Fetch, the register file and trap handling sit outside the block. The exception flag stands for cause 0, instruction address misaligned.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pc` loads the parameter `RESET_VEC`. After reset, no link write and no exception are signalled until `valid` is driven.
- R2: Opcode 1100011 is a conditional branch, with funct3 in bits 14:12 selecting the test. The codes are: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal. funct3 010 and 011 are never taken.
- R3: The branch offset is sign-extended from bit 12, with bit 0 zero. Its bits come from the instruction as follows: 12 from bit 31, 11 from bit 7, 10:5 from bits 30:25, and 4:1 from bits 11:8. A taken branch gives `next_pc` = `pc` + offset; a branch that is not taken gives `pc` + 4.
- R4: Opcode 1101111 always gives `next_pc` = `pc` + offset. The offset is sign-extended from bit 20, with bit 0 zero. Its bits come from the instruction as follows: 20 from bit 31, 19:12 from bits 19:12, 11 from bit 20, and 10:1 from bits 30:21.
- R5: Opcode 1100111 with funct3 000 forms its target as `rs1_val` plus the sign-extended bits 31:20. When bit 1 of that target is clear, `next_pc` is the target with bit 0 forced to zero.
- R6: When that target has bit 1 set, `misalign_exc` is high, `link_we` is low, `next_pc` equals `pc`, and the PC register keeps its value.
- R7: Both jumps assert `link_we` with `link_rd` = bits 11:7 and `link_data` = `pc` + 4. When that index is 0, `link_we` stays low.
- R8: Any other opcode gives `next_pc` = `pc` + 4, with no link write and no exception. This includes opcode 1100111 with a nonzero funct3.
- R9: While `valid` is low, `next_pc` equals `pc`, `link_we` and `misalign_exc` are low, and the PC register holds.
- R10: At a rising edge with `valid` high and no exception, `pc` takes the value `next_pc` showed before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Qualifies `instr` and the operands |
| instr | input | 32 | Instruction word |
| rs1_val | input | 32 | First source operand value |
| rs2_val | input | 32 | Second source operand value |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Program counter for the following instruction |
| link_we | output | 1 | Link register write enable |
| link_rd | output | 5 | Link register index |
| link_data | output | 32 | Link value, current PC plus four |
| misalign_exc | output | 1 | Indirect jump target misaligned |

## Verification
Directed branches use operand pairs whose signed and unsigned order disagree, such as -1 against 1. These separate the signed tests from the unsigned ones, and equal operands separate the equality tests from the ordering tests. Offsets at the extreme negative and positive values expose any misplaced or unextended immediate bit. Indirect jumps are tried with target low bits 00, 01, 10 and 11, which separates clearing bit 0 from raising the exception. Random mixes of branches, jumps, unrelated opcodes, destination index 0 and idle cycles then check that the PC chain stays consistent over many steps.

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid,
  input  logic [31:0] instr,
  input  logic [31:0] rs1_val,
  input  logic [31:0] rs2_val,
  output logic [31:0] pc,
  output logic [31:0] next_pc,
  output logic        link_we,
  output logic [4:0]  link_rd,
  output logic [31:0] link_data,
  output logic        misalign_exc
);

  localparam logic [6:0] OP_BRANCH = 7'b1100011;
  localparam logic [6:0] OP_JAL    = 7'b1101111;
  localparam logic [6:0] OP_JALR   = 7'b1100111;

  logic [6:0]  opcode;
  logic [2:0]  funct3;
  logic        is_br, is_jal, is_jalr;
  logic [31:0] br_off, jal_off, i_imm, jalr_tgt, seq_pc;
  logic        eq, lt_s, lt_u, taken;

  assign opcode  = instr[6:0];
  assign funct3  = instr[14:12];
  assign link_rd = instr[11:7];

  assign is_br   = valid && opcode == OP_BRANCH;
  assign is_jal  = valid && opcode == OP_JAL;
  assign is_jalr = valid && opcode == OP_JALR && funct3 == 3'b000;

  assign br_off  = {{19{instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
  assign jal_off = {{11{instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
  assign i_imm   = {{20{instr[31]}}, instr[31:20]};

  assign eq   = rs1_val == rs2_val;
  assign lt_s = $signed(rs1_val) < $signed(rs2_val);
  assign lt_u = rs1_val < rs2_val;

  always_comb begin
    case (funct3)
      3'b000:  taken = eq;
      3'b001:  taken = !eq;
      3'b100:  taken = lt_s;
      3'b101:  taken = !lt_s;
      3'b110:  taken = lt_u;
      3'b111:  taken = !lt_u;
      default: taken = 1'b0;
    endcase
  end

  assign seq_pc       = pc + 32'd4;
  assign jalr_tgt     = rs1_val + i_imm;
  assign misalign_exc = is_jalr && jalr_tgt[1];
  assign link_data    = seq_pc;
  assign link_we      = (is_jal || (is_jalr && !jalr_tgt[1])) && link_rd != 5'd0;

  always_comb begin
    if (!valid || misalign_exc) next_pc = pc;
    else if (is_jal)            next_pc = pc + jal_off;
    else if (is_jalr)           next_pc = {jalr_tgt[31:1], 1'b0};
    else if (is_br && taken)    next_pc = pc + br_off;
    else                        next_pc = seq_pc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      pc <= RESET_VEC;
    else if (valid && !misalign_exc) pc <= next_pc;
  end

endmodule

module npc_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid,
  input logic [31:0] instr,
  input logic [31:0] pc,
  input logic [31:0] next_pc,
  input logic        link_we,
  input logic [4:0]  link_rd,
  input logic        misalign_exc
);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> pc == $past(pc));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !link_we && !misalign_exc && next_pc == pc);

  // R6
  exc_no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_exc |-> !link_we);

  // R6
  exc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_exc |=> pc == $past(pc));

  // R10
  pc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !misalign_exc |=> pc == $past(next_pc));

  // R7
  link_rd_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> link_rd != 5'd0);

  // R5
  jalr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && instr[6:0] == 7'b1100111 && instr[14:12] == 3'b000 && !misalign_exc
      |-> next_pc[1:0] == 2'b00);

endmodule

bind npc_unit npc_unit_chk u_chk (.*);

// File: tb/tb_npc_unit.sv
module tb_npc_unit;

  localparam logic [31:0] RV = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n, valid;
  logic [31:0] instr, rs1_val, rs2_val;
  logic [31:0] pc, next_pc, link_data;
  logic        link_we, misalign_exc;
  logic [4:0]  link_rd;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_pc;

  always #5 clk = ~clk;

  npc_unit #(.RESET_VEC(RV)) dut (
    .clk(clk), .rst_n(rst_n), .valid(valid), .instr(instr),
    .rs1_val(rs1_val), .rs2_val(rs2_val), .pc(pc), .next_pc(next_pc),
    .link_we(link_we), .link_rd(link_rd), .link_data(link_data),
    .misalign_exc(misalign_exc));

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_b(logic [2:0] f3, logic [12:0] off);
    return {off[12], off[10:5], 5'd2, 5'd1, f3, off[4:1], off[11], 7'b1100011};
  endfunction

  function automatic logic [31:0] enc_j(logic [4:0] rd, logic [20:0] off);
    return {off[20], off[10:1], off[11], off[19:12], rd, 7'b1101111};
  endfunction

  function automatic logic [31:0] enc_jr(logic [4:0] rd, logic [11:0] imm);
    return {imm, 5'd1, 3'b000, rd, 7'b1100111};
  endfunction

  function automatic void model(input logic v, input logic [31:0] w, input logic [31:0] p,
                                input logic [31:0] a, input logic [31:0] b,
                                output logic [31:0] npc, output logic we, output logic exc);
    logic [12:0] bo;
    logic [20:0] jo;
    logic [31:0] t;
    logic        tk;
    npc = p + 4; we = 0; exc = 0;
    bo = {w[31], w[7], w[30:25], w[11:8], 1'b0};
    jo = {w[31], w[19:12], w[20], w[30:21], 1'b0};
    if (!v) begin npc = p; return; end
    if (w[6:0] == 7'b1100011) begin
      case (w[14:12])
        3'd0: tk = a == b;
        3'd1: tk = a != b;
        3'd4: tk = $signed(a) < $signed(b);
        3'd5: tk = $signed(a) >= $signed(b);
        3'd6: tk = a < b;
        3'd7: tk = a >= b;
        default: tk = 0;
      endcase
      if (tk) npc = p + 32'($signed(bo));
    end else if (w[6:0] == 7'b1101111) begin
      npc = p + 32'($signed(jo));
      we = w[11:7] != 0;
    end else if (w[6:0] == 7'b1100111 && w[14:12] == 0) begin
      t = a + 32'($signed(w[31:20]));
      if (t[1]) begin exc = 1; npc = p; end
      else begin npc = t & ~32'd1; we = w[11:7] != 0; end
    end
  endfunction

  task automatic step(string req, logic v, logic [31:0] w, logic [31:0] a, logic [31:0] b);
    logic [31:0] e_npc;
    logic        e_we, e_exc;
    @(negedge clk);
    valid = v; instr = w; rs1_val = a; rs2_val = b;
    #1;
    model(v, w, exp_pc, a, b, e_npc, e_we, e_exc);
    cmp(req, "next_pc", next_pc, e_npc);
    cmp(req, "link_we", 32'(link_we), 32'(e_we));
    cmp(req, "misalign_exc", 32'(misalign_exc), 32'(e_exc));
    if (e_we) begin
      cmp(req, "link_rd", 32'(link_rd), 32'(w[11:7]));
      cmp(req, "link_data", link_data, exp_pc + 4);
    end
    @(posedge clk); #1;
    if (v && !e_exc) exp_pc = e_npc;
    cmp("R10", "pc", pc, exp_pc);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 0; valid = 0; instr = 0; rs1_val = 0; rs2_val = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    exp_pc = RV;
    cmp("R1", "pc after reset", pc, RV);
    cmp("R1", "link_we after reset", 32'(link_we), 0);
    cmp("R1", "exc after reset", 32'(misalign_exc), 0);

    // R2 R3 equality, negative offset
    step("R2", 1, enc_b(3'b000, -13'sd16), 32'd5, 32'd5);
    step("R2", 1, enc_b(3'b001, 13'd64), 32'd5, 32'd5);
    // R2 signed vs unsigned disagreement
    step("R2", 1, enc_b(3'b100, 13'd8), 32'hFFFF_FFFF, 32'd1);
    step("R2", 1, enc_b(3'b110, 13'd8), 32'hFFFF_FFFF, 32'd1);
    step("R2", 1, enc_b(3'b101, 13'd12), 32'd1, 32'hFFFF_FFFF);
    step("R2", 1, enc_b(3'b111, 13'd12), 32'hFFFF_FFFF, 32'd1);
    step("R2", 1, enc_b(3'b010, 13'd40), 32'd0, 32'd9);
    // R3 extreme offsets
    step("R3", 1, enc_b(3'b000, 13'h1000), 32'd7, 32'd7);
    step("R3", 1, enc_b(3'b000, 13'h0FFE), 32'd7, 32'd7);
    // R4 R7 jumps
    step("R4", 1, enc_j(5'd1, 21'h100000), 0, 0);
    step("R4", 1, enc_j(5'd5, 21'h0FFFFE), 0, 0);
    step("R7", 1, enc_j(5'd0, 21'd24), 0, 0);
    // R5 R6 indirect targets with low bits 00, 01, 10, 11
    step("R5", 1, enc_jr(5'd3, 12'd0), 32'h0000_2000, 0);
    step("R5", 1, enc_jr(5'd3, 12'hFFF), 32'h0000_3002, 0);
    step("R6", 1, enc_jr(5'd3, 12'd2), 32'h0000_4000, 0);
    step("R6", 1, enc_jr(5'd3, 12'd3), 32'h0000_4000, 0);
    step("R7", 1, enc_jr(5'd0, 12'd4), 32'h0000_5000, 0);
    // R8 other opcodes
    step("R8", 1, 32'h0020_81B3, 1, 2);
    step("R8", 1, {12'd4, 5'd1, 3'b010, 5'd1, 7'b1100111}, 32'h100, 0);
    // R9 idle with a jump on the bus
    step("R9", 0, enc_j(5'd1, 21'd400), 0, 0);
    step("R9", 0, enc_jr(5'd1, 12'd2), 0, 0);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] w, a, b;
      int k;
      k = $urandom_range(0, 5);
      a = $urandom; b = ($urandom_range(0, 3) == 0) ? a : $urandom;
      w = $urandom;
      case (k)
        0, 1: w[6:0] = 7'b1100011;
        2:    w[6:0] = 7'b1101111;
        3:    begin w[6:0] = 7'b1100111; w[14:12] = 3'b000; end
        default: if (w[6:0] inside {7'b1100011, 7'b1101111, 7'b1100111}) w[6:0] = 7'b0010011;
      endcase
      if ($urandom_range(0, 7) == 0) w[11:7] = 5'd0;
      step("R2 R3 R4 R5 R6 R7 R8 R9", $urandom_range(0, 9) != 0, w, a, b);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule